// File: doc/BRIEF.md
# Prescaled Period Timer

This block is a 16-bit timer that software controls through a small word-addressed register bus. Three registers are visible: a control word, the running count and a period limit. Each one answers at four neighbouring word addresses. The first of these is a plain write. The other three clear, set or invert only the bits that are written as one, so one field can be changed without a read-modify-write sequence.

The count advances on prescaled events. An event is either a system clock cycle or a rising edge of an external clock, which passes through a synchronizer first. The system clock can also be gated by an input pin, so the timer totals the time that pin stays high. The prescaler divides the events by 1, 2, 4, 8, 16, 32, 64 or 256. When the count reaches the period value it returns to zero, and the block raises a one-cycle interrupt pulse.

Top module: `pptimer`

## Requirements
- R1: After reset, control reads 0x0000, count reads 0x0000, period reads 0xFFFF and irq is low.
- R2: The control group is at byte offset 0x00, count at 0x10 and period at 0x20. Within a group, +0x0 writes the value, +0x4 clears the bits written as one, +0x8 sets them, and +0xC inverts them. A read from any of the four aliases returns the current register value. Reads from 0x30 to 0x3C return 0.
- R3: Count and period keep only bits 15:0, and their upper bits read 0. Control keeps only bit 15 (on), bit 7 (gate), bits 6:4 (prescale code) and bit 1 (source), so writing all ones reads back 0x000080F2.
- R4: While control bit 15 is 0, the count holds its value unless software writes it.
- R5: With bit 1 = 0, bit 7 = 0 and code 0, the count rises by one on every clock edge after the edge that sets bit 15.
- R6: Prescale codes 0 to 7 give one tick per 1, 2, 4, 8, 16, 32, 64 and 256 events. A write to any control alias clears the prescaler's partial progress.
- R7: With bit 1 = 1, each rising edge of ext_clk produces one event after a two-flop synchronizer, however long ext_clk then stays high.
- R8: With bit 1 = 0 and bit 7 = 1, a clock edge is an event only while gate_in is high at that edge.
- R9: On a tick where count equals period, the count becomes 0 and irq is high for the cycle that follows that edge.
- R10: A write to a count alias in a given cycle wins over the increment in that cycle. The clear, set and invert aliases act on the count value before the increment.
- R11: If the count is above the period, it runs through 0xFFFF to 0x0000 and raises no irq on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| gate_in | input | 1 | Gate level for gated accumulation |
| irq | output | 1 | Period-match pulse |

## Verification
Read data is combinational, so a register write shows on bus_rdata in the cycle right after its write edge. The count moves at the same edge as the tick that causes it, and irq rises one edge after the matching tick. An ext_clk edge needs three edges before it is counted. The bench drives inputs and samples outputs only at falling edges, and each task counts the rising edges since its last write to predict the exact count and irq values. For external pulses the bench checks the total only after the synchronizer has settled, so the result does not depend on phase.

// File: rtl/pptimer_pkg.sv
package pptimer_pkg;

  localparam int BUS_W     = 32;
  localparam int CTRL_W    = 16;
  localparam int PS_CODE_W = 3;
  localparam int PS_W      = 8;

  localparam int ON_BIT   = 15;
  localparam int GATE_BIT = 7;
  localparam int PS_LSB   = 4;
  localparam int SRC_BIT  = 1;

  localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'h80F2;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    GRP_CTRL   = 2'd0,
    GRP_COUNT  = 2'd1,
    GRP_PERIOD = 2'd2,
    GRP_NONE   = 2'd3
  } reg_grp_e;

  // New register value for one alias access.
  function automatic logic [BUS_W-1:0] apply_alias(alias_op_e op,
                                                   logic [BUS_W-1:0] old_v,
                                                   logic [BUS_W-1:0] wd);
    logic [BUS_W-1:0] r;
    case (op)
      OP_WRITE: r = wd;
      OP_CLEAR: r = old_v & ~wd;
      OP_SET:   r = old_v | wd;
      default:  r = old_v ^ wd;
    endcase
    return r;
  endfunction

  // Terminal divider value, which is the ratio minus one. The top code jumps to 256.
  function automatic logic [PS_W-1:0] ps_limit(logic [PS_CODE_W-1:0] code);
    logic [PS_W-1:0] r;
    if (code == 3'd7) r = 8'hFF;
    else              r = (8'd1 << code) - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/pptimer_regs.sv
module pptimer_regs
  import pptimer_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [DW-1:0]     cnt_q,
  output logic              cnt_wr,
  output logic [DW-1:0]     cnt_wval,
  output logic              ctrl_wr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DW-1:0]     per_q
);

  logic      hit;
  reg_grp_e  grp;
  alias_op_e op;
  logic      per_wr;
  logic [CTRL_W-1:0] ctrl_next;
  logic [DW-1:0]     per_next;
  logic unused_addr_lsb;

  assign unused_addr_lsb = &{1'b0, bus_addr[1:0]};

  assign hit = ((bus_addr >> 6) == '0);
  assign grp = reg_grp_e'(bus_addr[5:4]);
  assign op  = alias_op_e'(bus_addr[3:2]);

  assign ctrl_wr = bus_we && hit && (grp == GRP_CTRL);
  assign cnt_wr  = bus_we && hit && (grp == GRP_COUNT);
  assign per_wr  = bus_we && hit && (grp == GRP_PERIOD);

  assign ctrl_next = CTRL_W'(apply_alias(op, BUS_W'(ctrl_q), bus_wdata)) & CTRL_KEEP;
  assign cnt_wval  = DW'(apply_alias(op, BUS_W'(cnt_q), bus_wdata));
  assign per_next  = DW'(apply_alias(op, BUS_W'(per_q), bus_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '1;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_next;
      if (per_wr)  per_q  <= per_next;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (grp)
        GRP_CTRL:   bus_rdata = BUS_W'(ctrl_q);
        GRP_COUNT:  bus_rdata = BUS_W'(cnt_q);
        GRP_PERIOD: bus_rdata = BUS_W'(per_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R3: bits outside the kept set never appear in the stored control word
  p_ctrl_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ((ctrl_q & ~CTRL_KEEP) == '0));

  // R2: the plain alias loads the written value
  p_plain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && op == OP_WRITE) |=> (per_q == $past(bus_wdata[DW-1:0])));

endmodule

// File: rtl/pptimer_tick.sv
module pptimer_tick
  import pptimer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_clk,
  input  logic                 gate_in,
  input  logic                 ctrl_on,
  input  logic                 ctrl_src,
  input  logic                 ctrl_gate,
  input  logic [PS_CODE_W-1:0] ps_code,
  input  logic                 ctrl_wr,
  output logic                 tick
);

  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic                 src_ev;
  logic                 ev;
  logic [PS_W-1:0]      div_q;
  logic [PS_W-1:0]      lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    if (ctrl_src)       src_ev = ext_rise;
    else if (ctrl_gate) src_ev = gate_in;
    else                src_ev = 1'b1;
  end

  assign ev   = ctrl_on & src_ev;
  assign lim  = ps_limit(ps_code);
  assign tick = ev && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (ctrl_wr) div_q <= '0;
    else if (ev)      div_q <= (div_q == lim) ? '0 : div_q + 8'd1;
  end

  // R6: a control write restarts the divider
  p_div_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (div_q == '0));

  // R7: a synchronized edge is one event only
  p_ext_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  // R4: no tick while the timer is off
  p_off_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_on |-> !tick);

endmodule

// File: rtl/pptimer_core.sv
module pptimer_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] per_q,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wval,
  output logic [DW-1:0] cnt_q,
  output logic          irq
);

  logic match;

  assign match = (cnt_q == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= cnt_wval;
      else if (tick) cnt_q <= match ? '0 : cnt_q + DW'(1);
      irq <= tick & match & ~cnt_wr;
    end
  end

  // R10: a software write wins over the increment
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cnt_wval)));

  // R5: a tick without a match steps the count by one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !match) |=> (cnt_q == $past(cnt_q) + DW'(1)));

  // R9: an interrupt pulse only follows a tick
  p_irq_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

endmodule

// File: rtl/pptimer.sv
module pptimer
  import pptimer_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_clk,
  input  logic             gate_in,
  output logic             irq
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     cnt_q;
  logic [DW-1:0]     per_q;
  logic [DW-1:0]     cnt_wval;
  logic              cnt_wr;
  logic              ctrl_wr;
  logic              tick;
  logic              ctrl_on;
  logic              unused_ctrl;

  assign ctrl_on     = ctrl_q[ON_BIT];
  assign unused_ctrl = &{1'b0, ctrl_q};

  pptimer_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .cnt_wr    (cnt_wr),
    .cnt_wval  (cnt_wval),
    .ctrl_wr   (ctrl_wr),
    .ctrl_q    (ctrl_q),
    .per_q     (per_q)
  );

  pptimer_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk   (ext_clk),
    .gate_in   (gate_in),
    .ctrl_on   (ctrl_on),
    .ctrl_src  (ctrl_q[SRC_BIT]),
    .ctrl_gate (ctrl_q[GATE_BIT]),
    .ps_code   (ctrl_q[PS_LSB +: PS_CODE_W]),
    .ctrl_wr   (ctrl_wr),
    .tick      (tick)
  );

  pptimer_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .per_q    (per_q),
    .cnt_wr   (cnt_wr),
    .cnt_wval (cnt_wval),
    .cnt_q    (cnt_q),
    .irq      (irq)
  );

  // R4: with the timer off and no write, the count holds
  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_on && !cnt_wr) |=> $stable(cnt_q));

endmodule

// File: tb/pptimer_test.sv
module pptimer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic        gate_in = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pptimer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .gate_in(gate_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ratio_of(input int code);
    return (code == 7) ? 256 : (1 << code);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); check("R1 ctrl", d, 32'h0);
    rd(6'h10, d); check("R1 count", d, 32'h0);
    rd(6'h20, d); check("R1 period", d, 32'h0000FFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(6'h20, 32'h0000_1234);
    wr(6'h28, 32'h0000_00F0);
    rd(6'h20, d); check("R2 set", d, 32'h12F4);
    wr(6'h24, 32'h0000_0204);
    rd(6'h24, d); check("R2 clear", d, 32'h10F0);
    wr(6'h2C, 32'h0000_FFFF);
    rd(6'h28, d); check("R2 invert", d, 32'hEF0F);
    rd(6'h30, d); check("R2 unmapped", d, 32'h0);
    wr(6'h20, 32'hFFFF_ABCD);
    rd(6'h2C, d); check("R3 period width", d, 32'h0000ABCD);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h08, d); check("R3 ctrl keep", d, 32'h000080F2);
    wr(6'h04, 32'h0000_FFFF);
    rd(6'h0C, d); check("R2 ctrl clear", d, 32'h0);
    rd(6'h10, d); check("R7 no ext edge", d, 32'h0);
    wr(6'h20, 32'h0000_FFFF);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(6'h10, 32'h0000_0055);
    idle(20);
    rd(6'h10, d); check("R4 hold", d, 32'h55);
    wr(6'h18, 32'h0000_0100);
    rd(6'h14, d); check("R2 count set", d, 32'h155);
  endtask

  task automatic t_internal();
    logic [31:0] d;
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0000_8000);
    idle(10);
    rd(6'h10, d); check("R5 ten edges", d, 32'd10);
    wr(6'h00, 32'h0);
    rd(6'h10, d); check("R5 last tick", d, 32'd11);
    idle(5);
    rd(6'h10, d); check("R4 stopped", d, 32'd11);
  endtask

  task automatic t_prescale(input int code, input int cycles);
    logic [31:0] d;
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h8000 | (code << 4));
    idle(cycles);
    rd(6'h10, d);
    check($sformatf("R6 code %0d", code), d, cycles / ratio_of(code));
  endtask

  task automatic t_div_restart();
    logic [31:0] d;
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0000_8030);
    idle(5);
    wr(6'h00, 32'h0000_8030);
    idle(7);
    rd(6'h10, d); check("R6 restart pending", d, 32'd0);
    idle(1);
    rd(6'h10, d); check("R6 restart tick", d, 32'd1);
  endtask

  task automatic t_count_prio();
    logic [31:0] d;
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0000_8000);
    idle(3);
    rd(6'h10, d); check("R5 running", d, 32'd3);
    wr(6'h10, 32'h0000_0200);
    rd(6'h10, d); check("R10 write wins", d, 32'h200);
    idle(1);
    rd(6'h10, d); check("R10 resumes", d, 32'h201);
    wr(6'h14, 32'h0000_0001);
    rd(6'h10, d); check("R10 clear alias", d, 32'h200);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_period();
    logic [31:0] d;
    int bad = 0;
    int pulses = 0;
    wr(6'h20, 32'd4);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0000_8000);
    for (int k = 1; k <= 20; k++) begin
      idle(1);
      rd(6'h10, d);
      if (d != 32'(k % 5)) bad++;
      if (irq !== ((k % 5) == 0)) bad++;
      if (irq === 1'b1) pulses++;
    end
    check("R9 sequence", bad, 0);
    check("R9 pulses", pulses, 4);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(6'h20, 32'd3);
    wr(6'h10, 32'h0000_FFFE);
    wr(6'h00, 32'h0000_8000);
    idle(1);
    rd(6'h10, d); check("R11 top", d, 32'hFFFF);
    idle(1);
    rd(6'h10, d); check("R11 wrap", d, 32'h0);
    check("R11 no irq", {31'b0, irq}, 32'h0);
    idle(1);
    rd(6'h10, d); check("R11 after", d, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h20, 32'h0000_FFFF);
  endtask

  task automatic t_external(input int code, input int pulses);
    logic [31:0] d;
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h8002 | (code << 4));
    for (int p = 0; p < pulses; p++) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
    idle(4);
    rd(6'h10, d);
    check($sformatf("R7 ext code %0d", code), d, pulses / ratio_of(code));
    wr(6'h00, 32'h0);
  endtask

  task automatic t_gated();
    logic [31:0] d;
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0000_8080);
    idle(5);
    rd(6'h10, d); check("R8 gate low", d, 32'd0);
    gate_in = 1'b1;
    idle(6);
    gate_in = 1'b0;
    rd(6'h10, d); check("R8 gate high", d, 32'd6);
    idle(5);
    rd(6'h10, d); check("R8 gate closed", d, 32'd6);
    wr(6'h00, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_alias();
    t_disabled();
    t_internal();
    t_prescale(1, 20);
    t_prescale(3, 40);
    t_prescale(6, 130);
    t_prescale(7, 600);
    t_div_restart();
    t_count_prio();
    t_period();
    t_wrap();
    t_external(0, 6);
    t_external(1, 6);
    t_gated();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule